// File: doc/BRIEF.md
# Serial SAR Converter Output Sequencer

This block is a clock-accurate digital model of the control and serial-output side of a 12-bit successive-approximation converter. A rising edge on the convert strobe opens a frame of 16 clock periods. The first period is the sampling phase, and the parallel sample word is captured on that edge. The next twelve periods shift the result out most significant bit first, in straight binary. The frame counter and a power flag are visible at the ports, so the surrounding logic can follow the sequence.

The same convert pin also controls the frame while it runs. The pin must stay high through the conversion. If it falls during clocks 1 to 12, the conversion is cut short: the output releases at once and the block powers down. If it falls during clock 13, the output also releases at once, and the block then powers down while it replays the word least significant bit first. If the pin stays high, the frame ends after clock 16 and the block returns to idle at full power. From idle, from power-down, or in the middle of a replay, a new rising edge starts a fresh frame.

Top module: `sar_serial_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `frame_cnt_o` is 0, `phase_o` is idle (code 0), `data_oe_o` is 0 and `low_pwr_o` is 0.
- R2: A rising edge of `conv_i` (low at one clock edge, high at the next) while the block is idle, powered down or replaying starts a frame. From the following cycle, `frame_cnt_o` is 1, `phase_o` is sample (code 1), `low_pwr_o` is 0, and the word on `sample_i` at that edge is captured. A `conv_i` that stays high without a rising edge starts nothing.
- R3: While `conv_i` stays high, the frame clocks k = 2 to 13 show `frame_cnt_o` = k, `phase_o` = convert (code 2) and `data_oe_o` = 1, and `data_o` carries bit 13-k of the captured word. Bit 11 comes out first and bit 0 last.
- R4: If `conv_i` is still high in clock 13, clocks 14 to 16 show `phase_o` idle with `data_oe_o` = 0. The cycle after that shows `frame_cnt_o` = 0 and `low_pwr_o` = 0, and the block stays there while `conv_i` keeps its level.
- R5: If `conv_i` is low during frame clocks 1 to 12, `data_oe_o` is 0 in that same cycle. From the next cycle, `frame_cnt_o` is 0, `low_pwr_o` is 1, and no further result bit is driven.
- R6: If `conv_i` is low during clock 13, `data_oe_o` is 0 in that same cycle. The next 11 cycles drive `data_oe_o` = 1 with word bits 1, 2, … 11 in that order, and `low_pwr_o` = 1.
- R7: After a replay ends, or after a short-cycle, the block stays powered down (`low_pwr_o` = 1, `data_oe_o` = 0) until a rising edge of `conv_i`.
- R8: `data_o` is 0 whenever `data_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Synchronous reset, active low |
| conv_i | input | 1 | Convert strobe, active high |
| sample_i | input | 12 | Parallel word standing in for the analog result |
| data_o | output | 1 | Serial result bit |
| data_oe_o | output | 1 | Output enable; 0 means the line is released |
| low_pwr_o | output | 1 | 1 while powered down (including replay) |
| phase_o | output | 2 | 0 idle, 1 sample, 2 convert |
| frame_cnt_o | output | 5 | Clock number within the frame, 0 outside a frame |

## Verification
Clock 13 is where two functions meet. In that cycle, the same falling edge of `conv_i` that releases the output, which is visible in the same cycle, also selects replay rather than a short-cycle, which becomes visible one cycle later. The bench drops the pin at clock 12 and at clock 13 on separate frames. It samples the enable one time step after the drop and again at the next falling clock edge. It requires power-down with no data after clock 12, and the D1-to-D11 replay after clock 13. A second overlap, a rising edge that lands during a replay, is provoked mid-replay and judged by a fresh sample phase carrying the new word.

// File: rtl/sar_seq_pkg.sv
// Package: shared state encoding and phase codes for the serial SAR sequencer.
// Assumes: the phase code values are part of the port contract.
package sar_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_REPLAY = 2'd2,
        ST_PDN    = 2'd3
    } seq_state_t;

    localparam logic [1:0] PH_IDLE   = 2'd0;
    localparam logic [1:0] PH_SAMPLE = 2'd1;
    localparam logic [1:0] PH_CONV   = 2'd2;

endpackage

// File: rtl/sar_conv_edge.sv
// Module: sar_conv_edge
// Registers the convert strobe and flags a low-to-high transition.
// Assumes: conv_i is already synchronous to clk.
module sar_conv_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic conv_i,
    output logic rise_o
);

    logic conv_q;

    // Purpose: keep the previous-cycle level of the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) conv_q <= 1'b0;
        else        conv_q <= conv_i;
    end

    // Purpose: a rise is high now after low last cycle.
    always_comb rise_o = conv_i & ~conv_q;

endmodule

// File: rtl/sar_frame_ctrl.sv
// Module: sar_frame_ctrl
// Frame state machine: the frame clock counter, short-cycle and replay
// selection, the replay index and the captured result word.
// Assumes: WIDTH >= 2 and FRAME_CLKS > WIDTH + 1.
module sar_frame_ctrl
    import sar_seq_pkg::*;
#(
    parameter int WIDTH      = 12,
    parameter int FRAME_CLKS = 16,
    localparam int CNT_W     = $clog2(FRAME_CLKS + 1),
    localparam int IDX_W     = $clog2(WIDTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_i,
    input  logic              rise_i,
    input  logic [WIDTH-1:0]  sample_i,
    output seq_state_t        state_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [IDX_W-1:0]  rep_o,
    output logic [WIDTH-1:0]  word_o
);

    localparam logic [CNT_W-1:0] CNT_FIRST = CNT_W'(1);
    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(WIDTH + 1);
    localparam logic [CNT_W-1:0] FRAME_END = CNT_W'(FRAME_CLKS);
    localparam logic [IDX_W-1:0] REP_LAST  = IDX_W'(WIDTH - 2);

    seq_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] rep;
    logic [WIDTH-1:0] word;

    // Purpose: advance the frame, including the pin gestures made mid-frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            rep   <= '0;
            word  <= '0;
        end else begin
            case (state)
                ST_IDLE, ST_PDN: begin
                    if (rise_i) begin
                        state <= ST_RUN;
                        cnt   <= CNT_FIRST;
                        word  <= sample_i;
                    end
                end
                ST_REPLAY: begin
                    if (rise_i) begin
                        state <= ST_RUN;
                        cnt   <= CNT_FIRST;
                        word  <= sample_i;
                    end else if (rep == REP_LAST) begin
                        state <= ST_PDN;
                    end else begin
                        rep <= rep + 1'b1;
                    end
                end
                ST_RUN: begin
                    if (!conv_i && cnt < LAST_BIT) begin
                        state <= ST_PDN;
                        cnt   <= '0;
                    end else if (!conv_i && cnt == LAST_BIT) begin
                        state <= ST_REPLAY;
                        cnt   <= '0;
                        rep   <= '0;
                    end else if (cnt == FRAME_END) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign state_o = state;
    assign cnt_o   = cnt;
    assign rep_o   = rep;
    assign word_o  = word;

endmodule

// File: rtl/sar_bit_mux.sv
// Module: sar_bit_mux
// Selects the serial bit and the output enable from the frame state.
// Assumes: in the run state, the output is released in the same cycle that
// conv_i is seen low.
module sar_bit_mux
    import sar_seq_pkg::*;
#(
    parameter int WIDTH      = 12,
    parameter int FRAME_CLKS = 16,
    localparam int CNT_W     = $clog2(FRAME_CLKS + 1),
    localparam int IDX_W     = $clog2(WIDTH),
    localparam int SLOTS     = 1 << IDX_W
) (
    input  seq_state_t        state_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [IDX_W-1:0]  rep_i,
    input  logic [WIDTH-1:0]  word_i,
    input  logic              conv_i,
    output logic              data_o,
    output logic              oe_o
);

    localparam logic [CNT_W-1:0] FIRST_BIT = CNT_W'(2);
    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(WIDTH + 1);

    logic [SLOTS-1:0] msb_order;
    logic [SLOTS-1:0] lsb_order;
    logic [CNT_W-1:0] run_off;
    logic [IDX_W-1:0] run_idx;
    logic [IDX_W-1:0] rep_idx;
    logic             run_window;

    // Purpose: build both bit orders, padded to a power of two.
    for (genvar j = 0; j < SLOTS; j++) begin : g_order
        if (j < WIDTH) begin : g_live
            assign msb_order[j] = word_i[WIDTH-1-j];
            assign lsb_order[j] = word_i[j];
        end else begin : g_pad
            assign msb_order[j] = 1'b0;
            assign lsb_order[j] = 1'b0;
        end
    end

    // Purpose: derive the bit index for each mode and the drive window.
    always_comb begin
        run_off    = cnt_i - FIRST_BIT;
        run_idx    = run_off[IDX_W-1:0];
        rep_idx    = rep_i + 1'b1;
        run_window = (state_i == ST_RUN) && (cnt_i >= FIRST_BIT) && (cnt_i <= LAST_BIT);
    end

    // Purpose: drive the serial line; it is forced low whenever it is released.
    always_comb begin
        oe_o   = 1'b0;
        data_o = 1'b0;
        if (run_window && conv_i) begin
            oe_o   = 1'b1;
            data_o = msb_order[run_idx];
        end else if (state_i == ST_REPLAY) begin
            oe_o   = 1'b1;
            data_o = lsb_order[rep_idx];
        end
    end

endmodule

// File: rtl/sar_serial_seq.sv
// Module: sar_serial_seq (top)
// Serial output sequencer of a successive-approximation converter: it handles
// the frame timing, the MSB-first output, the LSB-first replay, short-cycling
// and power-down, all controlled by one convert pin.
// Assumes: all inputs are synchronous to clk.
module sar_serial_seq
    import sar_seq_pkg::*;
#(
    parameter int WIDTH      = 12,
    parameter int FRAME_CLKS = 16,
    localparam int CNT_W     = $clog2(FRAME_CLKS + 1),
    localparam int IDX_W     = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_i,
    input  logic [WIDTH-1:0] sample_i,
    output logic             data_o,
    output logic             data_oe_o,
    output logic             low_pwr_o,
    output logic [1:0]       phase_o,
    output logic [CNT_W-1:0] frame_cnt_o
);

    localparam logic [CNT_W-1:0] CNT_FIRST = CNT_W'(1);
    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(WIDTH + 1);

    logic             rise;
    seq_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] rep;
    logic [WIDTH-1:0] word;

    sar_conv_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .conv_i (conv_i),
        .rise_o (rise)
    );

    sar_frame_ctrl #(.WIDTH(WIDTH), .FRAME_CLKS(FRAME_CLKS)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .conv_i   (conv_i),
        .rise_i   (rise),
        .sample_i (sample_i),
        .state_o  (state),
        .cnt_o    (cnt),
        .rep_o    (rep),
        .word_o   (word)
    );

    sar_bit_mux #(.WIDTH(WIDTH), .FRAME_CLKS(FRAME_CLKS)) u_mux (
        .state_i (state),
        .cnt_i   (cnt),
        .rep_i   (rep),
        .word_i  (word),
        .conv_i  (conv_i),
        .data_o  (data_o),
        .oe_o    (data_oe_o)
    );

    // Purpose: decode the phase and power indicators from the frame state.
    always_comb begin
        low_pwr_o = (state == ST_REPLAY) || (state == ST_PDN);
        if (state == ST_RUN && cnt == CNT_FIRST)
            phase_o = PH_SAMPLE;
        else if (state == ST_RUN && cnt > CNT_FIRST && cnt <= LAST_BIT)
            phase_o = PH_CONV;
        else
            phase_o = PH_IDLE;
    end

    assign frame_cnt_o = cnt;

endmodule

// File: rtl/sar_serial_seq_chk.sv
// Module: sar_serial_seq_chk
// Protocol checker bound to every sar_serial_seq instance; it watches ports only.
// Assumes: default WIDTH of 12, so clock 13 carries the last MSB-first bit.
module sar_serial_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        conv_i,
    input logic [11:0] sample_i,
    input logic        data_o,
    input logic        data_oe_o,
    input logic        low_pwr_o,
    input logic [1:0]  phase_o,
    input logic [4:0]  frame_cnt_o
);

    AST_RELEASED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe_o |-> !data_o);                                           // R8

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_cnt_o >= 5'd1 && frame_cnt_o <= 5'd12 && conv_i && !low_pwr_o)
        |=> frame_cnt_o == $past(frame_cnt_o) + 5'd1);                     // R3

    AST_SHORT_PDN: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_cnt_o >= 5'd1 && frame_cnt_o <= 5'd12 && !conv_i)
        |=> low_pwr_o && frame_cnt_o == 5'd0 && !data_oe_o);               // R5

    AST_LOW_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!conv_i && !low_pwr_o) |-> !data_oe_o);                           // R5

    AST_REPLAY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_cnt_o == 5'd13 && !conv_i) |=> low_pwr_o && data_oe_o);     // R6

    AST_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
        frame_cnt_o == 5'd16 |=> frame_cnt_o == 5'd0 && !low_pwr_o);       // R4

    AST_START: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(conv_i) && frame_cnt_o == 5'd0)
        |=> frame_cnt_o == 5'd1 && phase_o == 2'd1 && !low_pwr_o);         // R2

    AST_PDN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (low_pwr_o && !data_oe_o && !conv_i) |=> low_pwr_o);               // R7

endmodule

bind sar_serial_seq sar_serial_seq_chk u_chk (.*);

// File: tb/sar_serial_seq_tb.sv
// Bench: directed scenarios for sar_serial_seq, one task per scenario.
module sar_serial_seq_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        conv_i;
    logic [11:0] sample_i;
    logic        data_o;
    logic        data_oe_o;
    logic        low_pwr_o;
    logic [1:0]  phase_o;
    logic [4:0]  frame_cnt_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sar_serial_seq u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .conv_i      (conv_i),
        .sample_i    (sample_i),
        .data_o      (data_o),
        .data_oe_o   (data_oe_o),
        .low_pwr_o   (low_pwr_o),
        .phase_o     (phase_o),
        .frame_cnt_o (frame_cnt_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d @%0t", tag, act, exp, $time);
        end
    endtask

    // Compares every output against one expected set of values.
    task automatic expect_out(input string tag, input int cnt, input int ph,
                              input int oe, input int dat, input int pwr);
        check({tag, " cnt"},   frame_cnt_o, cnt);
        check({tag, " phase"}, phase_o, ph);
        check({tag, " oe"},    data_oe_o, oe);
        check({tag, " data"},  data_o, dat);
        check({tag, " pwr"},   low_pwr_o, pwr);
    endtask

    // Raises convert and checks the sample clock (R2).
    task automatic start_frame(input logic [11:0] w);
        @(negedge clk);
        sample_i = w;
        conv_i   = 1'b1;
        @(negedge clk);
        sample_i = ~w;
        expect_out("R2 start", 1, 1, 0, 0, 0);
    endtask

    // Steps through clocks 2..last with convert high, checking MSB-first bits (R3).
    task automatic msb_bits(input logic [11:0] w, input int last);
        for (int k = 2; k <= last; k++) begin
            @(negedge clk);
            expect_out("R3 msb", k, 2, 1, int'(w[13-k]), 0);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; conv_i = 1'b0; sample_i = '0;
        repeat (3) @(negedge clk);
        expect_out("R1 in reset", 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out("R1 after reset", 0, 0, 0, 0, 0);
    endtask

    task automatic t_normal(input logic [11:0] w);
        start_frame(w);
        msb_bits(w, 13);
        for (int k = 14; k <= 16; k++) begin
            @(negedge clk);
            expect_out("R4 tail", k, 0, 0, 0, 0);
        end
        @(negedge clk);
        expect_out("R4 idle", 0, 0, 0, 0, 0);
        repeat (2) @(negedge clk);
        expect_out("R2 level no restart", 0, 0, 0, 0, 0);
        conv_i = 1'b0;
        @(negedge clk);
        expect_out("R4 idle low", 0, 0, 0, 0, 0);
    endtask

    task automatic t_short(input logic [11:0] w, input int stop_k);
        start_frame(w);
        if (stop_k > 1) msb_bits(w, stop_k);
        conv_i = 1'b0;
        #1;
        check("R5 same-cycle release", data_oe_o, 0);
        check("R8 released data", data_o, 0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            expect_out("R5 short pdn", 0, 0, 0, 0, 1);
        end
        check("R7 held down", low_pwr_o, 1);
    endtask

    task automatic t_lsb(input logic [11:0] w);
        start_frame(w);
        msb_bits(w, 13);
        conv_i = 1'b0;
        #1;
        check("R6 same-cycle release", data_oe_o, 0);
        for (int i = 1; i <= 11; i++) begin
            @(negedge clk);
            expect_out("R6 replay", 0, 0, 1, int'(w[i]), 1);
        end
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            expect_out("R7 after replay", 0, 0, 0, 0, 1);
        end
        start_frame(w ^ 12'hFFF);
        conv_i = 1'b0;
        @(negedge clk);
        expect_out("R5 drop at clock 1", 0, 0, 0, 0, 1);
    endtask

    task automatic t_restart_replay(input logic [11:0] w, input logic [11:0] w2);
        start_frame(w);
        msb_bits(w, 13);
        conv_i = 1'b0;
        for (int i = 1; i <= 4; i++) begin
            @(negedge clk);
            expect_out("R6 replay part", 0, 0, 1, int'(w[i]), 1);
        end
        sample_i = w2;
        conv_i   = 1'b1;
        @(negedge clk);
        expect_out("R2 restart in replay", 1, 1, 0, 0, 0);
        msb_bits(w2, 3);
        conv_i = 1'b0;
        @(negedge clk);
        expect_out("R5 after restart", 0, 0, 0, 0, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_normal(12'hA5C);
        t_normal(12'h3F1);
        t_short(12'h800, 12);
        t_short(12'h5A6, 5);
        t_lsb(12'hC93);
        t_lsb(12'h001);
        t_restart_replay(12'h7E2, 12'hB4D);
        t_normal(12'h96F);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule